// File: doc/BRIEF.md
# Two-Channel Chained DMA Engine

This block is a small DMA engine with two channels that share one bus master port. Each channel copies data from a read address to a write address in single beats: it reads one item, then writes it. The number of beats, the item size (byte, half-word or word), whether each address advances after a beat, which request line paces the channel, and which channel is started when it finishes are all set per channel.

The intended use is a processor-free sample path. Channel 0 is paced by a peripheral's "sample ready" line. It moves each new sample byte into a small buffer in memory and, on completion, starts channel 1. Channel 1 moves the whole buffer word into a peripheral register and then starts channel 0 again. This forms a loop that runs with no further control. Software programs both channels and arms channel 0 before it starts the sampling peripheral, so that the first sample is not lost.

The master port issues one request at a time and holds it until `m_ready`. A narrow item is copied onto every byte lane of the write data. The byte strobes mark only the lanes selected by the low address bits, so a target that ignores strobes receives the item replicated across all four lanes.

Top module: `chain_dma_top`

## Requirements
- R1: After reset, `m_valid` stays low. No bus transfer happens for a programmed channel until its `start_i` bit is pulsed or another channel chains to it.
- R2: A channel whose request-select field (control bits [5:4]) is nonzero does not start a beat while the selected request line is low. Value k selects `req_i[k-1]`.
- R3: A paced channel with count 1 performs exactly one read-then-write beat for each sample made available on its request line.
- R4: Size 0 (control bits [1:0]) is byte. The byte is taken from read-data lane `rd_addr[1:0]`. It is written as four copies on `m_wdata`, with `m_be` = 1 << `wr_addr[1:0]`.
- R5: When a channel finishes its count, and its chain field (control bits [8 +: CH_W]) names the other channel, that channel is started. Channel 0 to channel 1 and back again forms an endless loop, one round per sample.
- R6: A channel whose chain field equals its own index stops after its last beat, and starts no further transfer.
- R7: A channel with request select 0 runs its beats back to back. When increment bits are set (control bit 2 for read, bit 3 for write), each address advances by the item size in bytes after every beat.
- R8: Only one beat is on the bus at a time. When both channels are ready, channel 0 goes first.
- R9: While `m_valid` is high and `m_ready` is low, `m_valid`, `m_addr`, `m_write` and `m_wdata` hold their values.
- R10: A chain trigger or a start reloads the channel's beat count and both addresses from the programmed values, so each round starts from the first address again.
- R11: Size 1 is half-word. It is taken from lane `rd_addr[1]`, written as two copies, with `m_be` = 4'b0011 or 4'b1100 chosen by `wr_addr[1]`. Size 2 is a full word with all strobes set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | CH_W | Channel selected by the configuration write |
| cfg_sel | input | 2 | 0 read address, 1 write address, 2 count, 3 control |
| cfg_wdata | input | 32 | Configuration write data |
| start_i | input | NCH | One-cycle pulse per channel that arms it |
| req_i | input | 2**REQ_SEL_W-1 | Pacing request lines |
| m_valid | output | 1 | Bus request valid |
| m_write | output | 1 | 1 write, 0 read |
| m_addr | output | 32 | Byte address |
| m_wdata | output | 32 | Write data, lanes replicated |
| m_be | output | 4 | Byte strobes |
| m_ready | input | 1 | Bus accepts the request this cycle |
| m_rdata | input | 32 | Read data, valid while a read is accepted |

## Verification
The assertions assume that software writes the configuration of a channel only while that channel is idle. They also assume that any channel reached by a chain has a nonzero programmed count, and that `m_rdata` is valid in the cycle a read is accepted. The bench follows these rules. Before each test it resets the engine and programs every channel in full before pulsing `start_i`. It uses only nonzero counts. It serves reads from a combinational memory model, so data is ready in the accept cycle. A sample is offered on the request line only after the previous sample has been read, which gives one sample per beat. One test makes `m_ready` toggle, so that held requests are exercised.

// File: rtl/dma_pkg.sv
// Package: shared types and field positions for the chained DMA engine.
// Assumes a 32-bit byte-addressed bus with four byte lanes.
package dma_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } xsize_e;

    // Configuration register select codes
    localparam logic [1:0] SEL_RD  = 2'd0;
    localparam logic [1:0] SEL_WR  = 2'd1;
    localparam logic [1:0] SEL_CNT = 2'd2;
    localparam logic [1:0] SEL_CTL = 2'd3;

    // Control word bit positions
    localparam int CTL_RINC  = 2;
    localparam int CTL_WINC  = 3;
    localparam int CTL_REQ   = 4;
    localparam int CTL_CHAIN = 8;

    // One beat as handed from a channel to the bus engine
    typedef struct packed {
        logic [31:0] rd;
        logic [31:0] wr;
        xsize_e      size;
    } beat_t;

endpackage

// File: rtl/dma_chan.sv
// Module: one DMA channel. It holds the programmed descriptor and the live
// addresses and remaining count, and it decides when a beat may be issued.
// Assumes: configuration is written only while the channel is idle, and
// beat_done_i is pulsed only for a beat this channel launched.
module dma_chan
    import dma_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int REQ_SEL_W = 2,
    parameter int CH_W      = 1,
    localparam int REQ_N    = (1 << REQ_SEL_W) - 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [1:0]           cfg_sel,
    input  logic [31:0]          cfg_wdata,
    input  logic                 load_i,
    input  logic [REQ_N-1:0]     req_i,
    input  logic                 beat_done_i,
    output logic                 ready_o,
    output logic                 active_o,
    output beat_t                desc_o,
    output logic                 done_o,
    output logic [CH_W-1:0]      chain_to_o
);

    logic [31:0]          prog_rd, prog_wr, cur_rd, cur_wr;
    logic [CNT_W-1:0]     prog_cnt, remain;
    xsize_e               size_q;
    logic                 rinc_q, winc_q, active_q, req_ok;
    logic [REQ_SEL_W-1:0] req_sel_q;
    logic [CH_W-1:0]      chain_q;
    logic [31:0]          step;

    // Purpose: pick the selected pacing line; select 0 means always allowed
    always_comb begin
        req_ok = (req_sel_q == '0);
        for (int k = 0; k < REQ_N; k++) begin
            if (req_sel_q == REQ_SEL_W'(k + 1)) req_ok = req_i[k];
        end
    end

    // Purpose: address step in bytes for the programmed item size
    always_comb begin
        case (size_q)
            SZ_BYTE: step = 32'd1;
            SZ_HALF: step = 32'd2;
            default: step = 32'd4;
        endcase
    end

    // Purpose: configuration registers and the live descriptor state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prog_rd   <= '0;
            prog_wr   <= '0;
            prog_cnt  <= '0;
            size_q    <= SZ_BYTE;
            rinc_q    <= 1'b0;
            winc_q    <= 1'b0;
            req_sel_q <= '0;
            chain_q   <= '0;
            cur_rd    <= '0;
            cur_wr    <= '0;
            remain    <= '0;
            active_q  <= 1'b0;
        end else begin
            if (cfg_we) begin
                case (cfg_sel)
                    SEL_RD:  prog_rd  <= cfg_wdata;
                    SEL_WR:  prog_wr  <= cfg_wdata;
                    SEL_CNT: prog_cnt <= cfg_wdata[CNT_W-1:0];
                    default: begin
                        size_q    <= xsize_e'(cfg_wdata[1:0]);
                        rinc_q    <= cfg_wdata[CTL_RINC];
                        winc_q    <= cfg_wdata[CTL_WINC];
                        req_sel_q <= cfg_wdata[CTL_REQ +: REQ_SEL_W];
                        chain_q   <= cfg_wdata[CTL_CHAIN +: CH_W];
                    end
                endcase
            end
            if (load_i) begin
                cur_rd   <= prog_rd;
                cur_wr   <= prog_wr;
                remain   <= prog_cnt;
                active_q <= (prog_cnt != '0);
            end else if (beat_done_i) begin
                if (rinc_q) cur_rd <= cur_rd + step;
                if (winc_q) cur_wr <= cur_wr + step;
                remain <= remain - 1'b1;
                if (remain == CNT_W'(1)) active_q <= 1'b0;
            end
        end
    end

    assign ready_o     = active_q && req_ok;
    assign active_o    = active_q;
    assign desc_o      = '{rd: cur_rd, wr: cur_wr, size: size_q};
    assign done_o      = beat_done_i && (remain == CNT_W'(1));
    assign chain_to_o  = chain_q;

    AST_COUNT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        active_q |-> (remain != '0)); // R7

    AST_BEAT_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        beat_done_i |-> active_q); // R7

endmodule

// File: rtl/dma_arb.sv
// Module: fixed-priority arbiter; the lowest-numbered ready channel wins.
// Assumes the bus engine samples the result only when it is idle.
module dma_arb #(
    parameter int NCH = 2,
    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCH-1:0]  ready_i,
    output logic [CH_W-1:0] idx_o,
    output logic            any_o
);

    logic [NCH-1:0] gnt;

    // Purpose: scan from the top so the lowest ready index is kept last
    always_comb begin
        gnt   = '0;
        idx_o = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (ready_i[i]) begin
                gnt   = '0;
                gnt[i] = 1'b1;
                idx_o = CH_W'(i);
            end
        end
    end

    assign any_o = |ready_i;

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        any_o |-> $onehot0(gnt) && (gnt != '0)); // R8

endmodule

// File: rtl/dma_xfer.sv
// Module: bus engine. It runs one beat at a time, a read and then a write,
// extracts the item from its read lane and replicates it on write.
// Assumes read data is valid in the cycle m_ready accepts a read.
module dma_xfer
    import dma_pkg::*;
#(
    parameter int NCH = 2,
    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            any_i,
    input  logic [CH_W-1:0] idx_i,
    input  beat_t           desc_i,
    output logic [NCH-1:0]  beat_done_o,
    output logic            m_valid,
    output logic            m_write,
    output logic [31:0]     m_addr,
    output logic [31:0]     m_wdata,
    output logic [3:0]      m_be,
    input  logic            m_ready,
    input  logic [31:0]     m_rdata
);

    typedef enum logic [1:0] {X_IDLE, X_RD, X_WR} xstate_e;

    xstate_e         state;
    beat_t           desc_q;
    logic [CH_W-1:0] ch_q;
    logic [31:0]     data_q, lane_data, repl;
    logic [3:0]      wr_be;

    // Purpose: pick the addressed item out of the read word
    always_comb begin
        case (desc_q.size)
            SZ_BYTE: lane_data = {24'b0, m_rdata[{desc_q.rd[1:0], 3'b000} +: 8]};
            SZ_HALF: lane_data = {16'b0, m_rdata[{desc_q.rd[1], 4'b0000} +: 16]};
            default: lane_data = m_rdata;
        endcase
    end

    // Purpose: replicate the item on all lanes and set strobes for the target
    always_comb begin
        case (desc_q.size)
            SZ_BYTE: begin
                repl  = {4{data_q[7:0]}};
                wr_be = 4'b0001 << desc_q.wr[1:0];
            end
            SZ_HALF: begin
                repl  = {2{data_q[15:0]}};
                wr_be = desc_q.wr[1] ? 4'b1100 : 4'b0011;
            end
            default: begin
                repl  = data_q;
                wr_be = 4'b1111;
            end
        endcase
    end

    // Purpose: beat sequencer, idle to read to write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= X_IDLE;
            desc_q <= '0;
            ch_q   <= '0;
            data_q <= '0;
        end else begin
            case (state)
                X_IDLE: if (any_i) begin
                    desc_q <= desc_i;
                    ch_q   <= idx_i;
                    state  <= X_RD;
                end
                X_RD: if (m_ready) begin
                    data_q <= lane_data;
                    state  <= X_WR;
                end
                default: if (m_ready) state <= X_IDLE;
            endcase
        end
    end

    // Purpose: completion pulse to the channel that owns the beat
    always_comb begin
        beat_done_o = '0;
        for (int i = 0; i < NCH; i++) begin
            beat_done_o[i] = (state == X_WR) && m_ready && (ch_q == CH_W'(i));
        end
    end

    assign m_valid = (state != X_IDLE);
    assign m_write = (state == X_WR);
    assign m_addr  = (state == X_WR) ? desc_q.wr : desc_q.rd;
    assign m_wdata = (state == X_WR) ? repl : 32'b0;
    assign m_be    = (state == X_WR) ? wr_be : 4'b1111;

    AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> m_valid && $stable(m_addr)
            && $stable(m_write) && $stable(m_wdata)); // R9

endmodule

// File: rtl/chain_dma_top.sv
// Module: two-channel chained DMA top. It wires the channels, the arbiter
// and the bus engine, and routes each channel's completion to the channel
// named in its chain field.
// Assumes chained-to channels are programmed with a nonzero count.
module chain_dma_top
    import dma_pkg::*;
#(
    parameter int NCH       = 2,
    parameter int CNT_W     = 16,
    parameter int REQ_SEL_W = 2,
    localparam int CH_W     = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int REQ_N    = (1 << REQ_SEL_W) - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CH_W-1:0]  cfg_ch,
    input  logic [1:0]       cfg_sel,
    input  logic [31:0]      cfg_wdata,
    input  logic [NCH-1:0]   start_i,
    input  logic [REQ_N-1:0] req_i,
    output logic             m_valid,
    output logic             m_write,
    output logic [31:0]      m_addr,
    output logic [31:0]      m_wdata,
    output logic [3:0]       m_be,
    input  logic             m_ready,
    input  logic [31:0]      m_rdata
);

    logic [NCH-1:0]  ready, active, done, trig, load, beat_done;
    beat_t           desc [NCH];
    logic [CH_W-1:0] chain_to [NCH];
    logic [CH_W-1:0] gnt_idx;
    logic            gnt_any;

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            // Purpose: collect chain triggers aimed at this channel
            always_comb begin
                trig[c] = 1'b0;
                for (int s = 0; s < NCH; s++) begin
                    if (s != c && done[s] && chain_to[s] == CH_W'(c)) trig[c] = 1'b1;
                end
            end
            assign load[c] = start_i[c] | trig[c];

            dma_chan #(
                .CNT_W(CNT_W), .REQ_SEL_W(REQ_SEL_W), .CH_W(CH_W)
            ) chan_i (
                .clk(clk), .rst_n(rst_n),
                .cfg_we(cfg_we && cfg_ch == CH_W'(c)),
                .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
                .load_i(load[c]), .req_i(req_i),
                .beat_done_i(beat_done[c]),
                .ready_o(ready[c]), .active_o(active[c]),
                .desc_o(desc[c]), .done_o(done[c]),
                .chain_to_o(chain_to[c])
            );

            AST_CHAIN_ARM: assert property (@(posedge clk) disable iff (!rst_n)
                (done[c] && chain_to[c] != CH_W'(c)) |=> active[$past(chain_to[c])]); // R5
        end
    endgenerate

    dma_arb #(.NCH(NCH)) arb_i (
        .clk(clk), .rst_n(rst_n), .ready_i(ready),
        .idx_o(gnt_idx), .any_o(gnt_any)
    );

    dma_xfer #(.NCH(NCH)) xfer_i (
        .clk(clk), .rst_n(rst_n),
        .any_i(gnt_any), .idx_i(gnt_idx), .desc_i(desc[gnt_idx]),
        .beat_done_o(beat_done),
        .m_valid(m_valid), .m_write(m_write), .m_addr(m_addr),
        .m_wdata(m_wdata), .m_be(m_be), .m_ready(m_ready), .m_rdata(m_rdata)
    );

endmodule

// File: tb/chain_dma_top_tb_top.sv
// Directed bench: a memory model, a sample source at SRC_A and a sink
// register at REG_A. Every write on the bus is logged and checked.
module chain_dma_top_tb_top;

    localparam logic [31:0] SRC_A = 32'h100;
    localparam logic [31:0] REG_A = 32'h200;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [0:0]  cfg_ch = '0;
    logic [1:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic [1:0]  start_i = '0;
    logic [2:0]  req_i;
    logic        m_valid, m_write, m_ready;
    logic [31:0] m_addr, m_wdata, m_rdata;
    logic [3:0]  m_be;

    logic [31:0] mem [32];
    logic [31:0] sink_q = '0;
    logic [7:0]  samp_val = '0;
    int          pushes = 0, pops = 0;
    logic        stall_mode = 1'b0, tog = 1'b0;
    int          wcnt = 0;
    logic [31:0] wl_addr [256];
    logic [31:0] wl_data [256];
    logic [3:0]  wl_be [256];
    int          nrun = 0, nfail = 0, cyc = 0;
    bit          finished = 0;

    always #5 clk = ~clk;

    chain_dma_top dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .start_i(start_i),
        .req_i(req_i), .m_valid(m_valid), .m_write(m_write), .m_addr(m_addr),
        .m_wdata(m_wdata), .m_be(m_be), .m_ready(m_ready), .m_rdata(m_rdata)
    );

    assign req_i   = {2'b00, pushes != pops};
    assign m_ready = !stall_mode || tog;
    assign m_rdata = (m_addr == SRC_A) ? {24'b0, samp_val} :
                     (m_addr == REG_A) ? sink_q : mem[m_addr[6:2]];

    always @(negedge clk) tog <= ~tog;

    // Slave side effects and write log
    always @(posedge clk) begin
        if (rst_n && m_valid && m_ready) begin
            if (m_write) begin
                wl_addr[wcnt[7:0]] <= m_addr;
                wl_data[wcnt[7:0]] <= m_wdata;
                wl_be[wcnt[7:0]]   <= m_be;
                wcnt <= wcnt + 1;
                if (m_addr == REG_A) sink_q <= m_wdata;
                else if (m_addr < 32'h80) begin
                    for (int b = 0; b < 4; b++)
                        if (m_be[b]) mem[m_addr[6:2]][8*b +: 8] <= m_wdata[8*b +: 8];
                end
            end else if (m_addr == SRC_A) begin
                pops <= pops + 1;
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !finished) begin
            finished = 1;
            nfail++;
            $display("FAIL watchdog act=%0d exp=<150000", cyc);
            $display("[TB] %0d tests run, %0d failed", nrun, nfail);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nrun++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        stall_mode = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic cfg(input int ch, input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_ch = ch[0:0]; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic logic [31:0] ctl(input int sz, input bit ri, input bit wi, input int rq, input int chn);
        return 32'(sz) | (32'(ri) << 2) | (32'(wi) << 3) | (32'(rq) << 4) | (32'(chn) << 8);
    endfunction

    task automatic prog(input int ch, input logic [31:0] rd, input logic [31:0] wr, input int cnt, input logic [31:0] c);
        cfg(ch, 2'd0, rd);
        cfg(ch, 2'd1, wr);
        cfg(ch, 2'd2, 32'(cnt));
        cfg(ch, 2'd3, c);
    endtask

    task automatic start(input logic [1:0] m);
        @(negedge clk);
        start_i = m;
        @(negedge clk);
        start_i = '0;
    endtask

    task automatic wait_writes(input int target, input string tag);
        int t = 0;
        while (wcnt < target && t < 400) begin
            @(negedge clk);
            t++;
        end
        check(wcnt >= target, tag, 32'(wcnt), 32'(target));
    endtask

    task automatic push(input logic [7:0] v);
        int t = 0;
        while (pushes != pops && t < 400) begin
            @(negedge clk);
            t++;
        end
        samp_val = v;
        pushes++;
    endtask

    task automatic expect_w(input int i, input logic [31:0] a, input logic [31:0] d, input logic [3:0] be, input string tag);
        check(wl_addr[i[7:0]] == a, tag, wl_addr[i[7:0]], a);
        check(wl_data[i[7:0]] == d, tag, wl_data[i[7:0]], d);
        check(wl_be[i[7:0]] == be, tag, 32'(wl_be[i[7:0]]), 32'(be));
    endtask

    // Test: idle after reset and while programmed but not started
    task automatic t_reset();
        int base;
        do_reset();
        base = wcnt;
        check(m_valid == 1'b0, "R1 reset valid", 32'(m_valid), 0);
        prog(0, 32'h0, 32'h20, 1, ctl(2, 0, 0, 0, 0));
        repeat (10) begin
            @(negedge clk);
            check(m_valid == 1'b0, "R1 unstarted idle", 32'(m_valid), 0);
        end
        check(wcnt == base, "R1 no writes", 32'(wcnt - base), 0);
    endtask

    // Test: ping-pong loop driven by samples
    task automatic t_loop();
        int base;
        do_reset();
        mem[16] = 32'h0;
        prog(0, SRC_A, 32'h40, 1, ctl(0, 0, 0, 1, 1));
        prog(1, 32'h40, REG_A, 1, ctl(2, 0, 0, 0, 0));
        start(2'b01);
        base = wcnt;
        repeat (20) @(negedge clk);
        check(wcnt == base, "R2 waits for request", 32'(wcnt - base), 0);
        check(m_valid == 1'b0, "R2 bus idle", 32'(m_valid), 0);
        push(8'hA5);
        wait_writes(base + 2, "R5 first round");
        expect_w(base, 32'h40, 32'hA5A5A5A5, 4'b0001, "R4 byte replicated");
        expect_w(base + 1, REG_A, 32'h000000A5, 4'b1111, "R5 buffer to register");
        repeat (20) @(negedge clk);
        check(wcnt == base + 2, "R3 one beat per sample", 32'(wcnt - base), 2);
        push(8'h3C);
        wait_writes(base + 4, "R5 loop repeats");
        expect_w(base + 2, 32'h40, 32'h3C3C3C3C, 4'b0001, "R3 second sample");
        check(sink_q == 32'h0000003C, "R5 register value", sink_q, 32'h3C);
    endtask

    // Test: unpaced byte copy with increments; optional bus stalls
    task automatic t_copy(input bit stall, input string tag);
        int base;
        do_reset();
        stall_mode = stall;
        mem[0] = 32'h44332211;
        mem[8] = 32'h0;
        prog(0, 32'h0, 32'h20, 4, ctl(0, 1, 1, 0, 0));
        base = wcnt;
        start(2'b01);
        wait_writes(base + 4, tag);
        expect_w(base,     32'h20, 32'h11111111, 4'b0001, "R7 beat0 lane0");
        expect_w(base + 1, 32'h21, 32'h22222222, 4'b0010, "R7 beat1 lane1");
        expect_w(base + 2, 32'h22, 32'h33333333, 4'b0100, "R4 beat2 lane2");
        expect_w(base + 3, 32'h23, 32'h44444444, 4'b1000, "R4 beat3 lane3");
        repeat (20) @(negedge clk);
        check(wcnt == base + 4, "R6 self chain stops", 32'(wcnt - base), 4);
        check(mem[8] == 32'h44332211, tag, mem[8], 32'h44332211);
    endtask

    // Test: half-word items
    task automatic t_half();
        int base;
        do_reset();
        mem[1] = 32'h87654321;
        prog(0, 32'h4, 32'h30, 2, ctl(1, 1, 1, 0, 0));
        base = wcnt;
        start(2'b01);
        wait_writes(base + 2, "R11 half beats");
        expect_w(base,     32'h30, 32'h43214321, 4'b0011, "R11 low half");
        expect_w(base + 1, 32'h32, 32'h87658765, 4'b1100, "R11 high half");
    endtask

    // Test: both channels ready together
    task automatic t_prio();
        int base;
        do_reset();
        mem[0] = 32'h44332211;
        mem[1] = 32'h87654321;
        prog(0, 32'h0, 32'h50, 1, ctl(2, 0, 0, 0, 0));
        prog(1, 32'h4, 32'h54, 1, ctl(2, 0, 0, 0, 1));
        base = wcnt;
        start(2'b11);
        wait_writes(base + 2, "R8 both beats");
        expect_w(base,     32'h50, 32'h44332211, 4'b1111, "R8 channel 0 first");
        expect_w(base + 1, 32'h54, 32'h87654321, 4'b1111, "R8 channel 1 second");
    endtask

    // Test: chain restarts from programmed count and addresses
    task automatic t_reload();
        int base;
        do_reset();
        mem[24] = 32'h0;
        prog(0, SRC_A, 32'h60, 2, ctl(0, 0, 1, 1, 1));
        prog(1, 32'h60, REG_A, 1, ctl(2, 0, 0, 0, 0));
        start(2'b01);
        base = wcnt;
        push(8'h11);
        push(8'h22);
        wait_writes(base + 3, "R10 round one");
        check(sink_q == 32'h00002211, "R10 round one value", sink_q, 32'h2211);
        push(8'h33);
        push(8'h44);
        wait_writes(base + 6, "R10 round two");
        expect_w(base + 3, 32'h60, 32'h33333333, 4'b0001, "R10 address reloaded");
        expect_w(base + 4, 32'h61, 32'h44444444, 4'b0010, "R10 second beat");
        check(sink_q == 32'h00004433, "R10 round two value", sink_q, 32'h4433);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) mem[i] = '0;
        t_reset();
        t_loop();
        t_copy(1'b0, "R7 byte copy");
        t_copy(1'b1, "R9 copy with stalls");
        t_half();
        t_prio();
        t_reload();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", nrun, nfail);
            $finish;
        end
    end

endmodule